// File: doc/BRIEF.md
# I2C Transfer Command Sequencer

This block sits in front of the command FIFO of an I2C master controller. It takes one transfer descriptor at a time and turns it into a stream of command words. A descriptor gives a write length, a second length, a read/write mode and two condition flags. In write mode the second length counts more bytes to send. In read mode it counts bytes to request and then collect. The sequencer runs the transfer in two phases. The first phase sends the leading write bytes. The second phase sends the remaining write bytes, or it issues one read request per byte that is expected back.

The controller reports its FIFO fill levels and two wake events to the block. The block tells the controller which wake sources to enable and which thresholds to use. When the transmit FIFO is full, the block parks until the level drops to a threshold. While reads are outstanding, it keeps a small reserve of transmit space free. Received bytes are drained into an output stream. When the transfer ends, the block reports a single-cycle completion with a status code. A transmit abort or an external timeout ends the transfer early.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: Free transmit space is FIFO_DEPTH minus `tx_level`; no command word is pushed while that space is zero.
- R2: A read request is pushed only while the free space exceeds RX_SLACK (default 2), so the transmit level never passes FIFO_DEPTH-RX_SLACK while reads are issued.
- R3: `cmd_word` layout: bits 7:0 are the data byte, bit 8 marks a read request (data 0), bit 9 is stop, bit 10 is restart; data bytes come from `wr_data` (taken when `wr_ready`), and read requests are used only in the second phase of a read.
- R4: Word positions are counted from 1 across both phases. Restart is set on word 1 only if `desc_restart` is high. Stop is set only on the word whose position equals `desc_len0+desc_len1`, and only if `desc_stop` is high. No flag is added where a read follows writes.
- R5: Phase one issues `desc_len0` data words. Phase two issues `desc_len1` data words in write mode, or `desc_len1` read requests in read mode.
- R6: A read whose `desc_len0` is zero starts directly with read requests.
- R7: When commands remain but no space is left, the block raises `tx_wake_en` with `tx_thresh`=TX_WAKE_LVL (default 16) and resumes only on `tx_empty`.
- R8: After the last command of a write, the block waits on `tx_empty` with `tx_thresh`=0. After the last request of a read, it raises `rx_wake_en` with `rx_thresh` equal to the outstanding byte count minus 1. On a wake, it pops `rx_level` bytes with `rx_pop`, one per cycle, and shows each one on `rd_valid`/`rd_data`.
- R9: If `rx_level` exceeds the outstanding receive count, the transfer ends with status ERROR.
- R10: `done_valid` pulses for one cycle with `done_status` OK=0, ERROR=1 (on `xfer_abort`) or TIMEOUT=2 (on `xfer_timeout`). Both wake enables are low while it is high.
- R11: `desc_ready` is high only when idle. A descriptor is taken on `desc_valid && desc_ready`, and `desc_valid` has no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Idle, descriptor accepted |
| desc_read | input | 1 | 1 = write-then-read, 0 = write-then-write |
| desc_restart | input | 1 | Restart wanted on first word |
| desc_stop | input | 1 | Stop wanted on last word |
| desc_len0 | input | CNT_W | Phase-one write byte count |
| desc_len1 | input | CNT_W | Phase-two write or read byte count |
| wr_valid | input | 1 | Write byte available |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Write byte consumed |
| cmd_push | output | 1 | Push command word into FIFO |
| cmd_word | output | 11 | Command word (R3 layout) |
| tx_level | input | LVL_W | Command FIFO fill level |
| tx_thresh | output | LVL_W | Transmit wake threshold |
| tx_wake_en | output | 1 | Transmit-empty wake enabled |
| tx_empty | input | 1 | Transmit level at/below threshold |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_data | input | 8 | Receive FIFO head byte |
| rx_pop | output | 1 | Pop receive FIFO |
| rx_thresh | output | CNT_W | Receive wake threshold |
| rx_wake_en | output | 1 | Receive-full wake enabled |
| rx_full | input | 1 | Receive level above threshold |
| rd_valid | output | 1 | Received byte valid |
| rd_data | output | 8 | Received byte |
| xfer_abort | input | 1 | Transmit abort from controller |
| xfer_timeout | input | 1 | Transfer timeout |
| done_valid | output | 1 | Completion pulse |
| done_status | output | 2 | Completion status |

## Verification
The block is run on a short write-write with both flags and on a write-then-read with only stop, which checks that no restart appears where the direction changes. A read with an empty first phase checks the phase skip. A slowly drained 100-byte read exposes the slack reserve and the threshold-16 wait. A 120-byte write does the same for a full FIFO and for the final drain wait. An abort on a stalled controller, a timeout, an injected surplus receive byte and a flagless single byte tell the three status outcomes and the default flag state apart.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_FILL, S_WAIT_TX, S_WAIT_END, S_DRAIN
    } seq_state_e;

    typedef enum logic [1:0] {
        XS_OK = 2'd0, XS_ERROR = 2'd1, XS_TIMEOUT = 2'd2
    } xfer_status_e;

    typedef struct packed {
        logic       restart;
        logic       stop;
        logic       rd_req;
        logic [7:0] dat;
    } cmd_t;
endpackage

// File: rtl/i2cseq_space.sv
module i2cseq_space #(
    parameter int FIFO_DEPTH = 64,
    parameter int RX_SLACK   = 2,
    parameter int LVL_W      = 7
) (
    input  logic [LVL_W-1:0] level,
    input  logic             read_req,
    output logic             room
);
    localparam logic [LVL_W:0] DEPTH_V = (LVL_W+1)'(FIFO_DEPTH);
    localparam logic [LVL_W:0] SLACK_V = (LVL_W+1)'(RX_SLACK);
    logic [LVL_W:0] free_w;

    assign free_w = DEPTH_V - {1'b0, level};
    assign room   = read_req ? (free_w > SLACK_V) : (free_w != '0);
endmodule

// File: rtl/i2cseq_fmt.sv
module i2cseq_fmt #(
    parameter int BC_W = 9
) (
    input  logic [BC_W-1:0]   pos,
    input  logic [BC_W-1:0]   last_pos,
    input  logic              want_rs,
    input  logic              want_sp,
    input  logic              is_req,
    input  logic [7:0]        data,
    output i2cseq_pkg::cmd_t  word
);
    always_comb begin
        word.restart = want_rs && (pos == BC_W'(1));
        word.stop    = want_sp && (pos == last_pos);
        word.rd_req  = is_req;
        word.dat     = is_req ? 8'h00 : data;
    end
endmodule

// File: rtl/i2c_cmd_sequencer.sv
module i2c_cmd_sequencer #(
    parameter int FIFO_DEPTH  = 64,
    parameter int RX_SLACK    = 2,
    parameter int TX_WAKE_LVL = 16,
    parameter int CNT_W       = 8,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1),
    localparam int BC_W       = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    output logic             desc_ready,
    input  logic             desc_read,
    input  logic             desc_restart,
    input  logic             desc_stop,
    input  logic [CNT_W-1:0] desc_len0,
    input  logic [CNT_W-1:0] desc_len1,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    output logic             wr_ready,
    output logic             cmd_push,
    output logic [10:0]      cmd_word,
    input  logic [LVL_W-1:0] tx_level,
    output logic [LVL_W-1:0] tx_thresh,
    output logic             tx_wake_en,
    input  logic             tx_empty,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [7:0]       rx_data,
    output logic             rx_pop,
    output logic [CNT_W-1:0] rx_thresh,
    output logic             rx_wake_en,
    input  logic             rx_full,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    input  logic             xfer_abort,
    input  logic             xfer_timeout,
    output logic             done_valid,
    output logic [1:0]       done_status
);
    import i2cseq_pkg::*;

    typedef struct packed {
        seq_state_e       st;
        logic             rd;
        logic             rs;
        logic             sp;
        logic             ph1;
        logic [CNT_W-1:0] c0;
        logic [CNT_W-1:0] c1;
        logic [BC_W-1:0]  bc;
        logic [BC_W-1:0]  bend;
        logic             done;
        xfer_status_e     status;
    } seq_t;

    seq_t q, d;
    logic room, is_req, push;
    cmd_t word;

    assign is_req = q.rd && !q.ph1;

    i2cseq_space #(.FIFO_DEPTH(FIFO_DEPTH), .RX_SLACK(RX_SLACK), .LVL_W(LVL_W)) u_space (
        .level(tx_level), .read_req(is_req), .room(room)
    );

    i2cseq_fmt #(.BC_W(BC_W)) u_fmt (
        .pos(q.bc + BC_W'(1)), .last_pos(q.bend), .want_rs(q.rs), .want_sp(q.sp),
        .is_req(is_req), .data(wr_data), .word(word)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        push   = 1'b0;
        rx_pop = 1'b0;
        if (q.st == S_IDLE) begin
            if (desc_valid) begin
                d.rd   = desc_read;
                d.rs   = desc_restart;
                d.sp   = desc_stop;
                d.c1   = desc_len1;
                d.bc   = '0;
                d.bend = BC_W'(desc_len0) + BC_W'(desc_len1);
                d.st   = S_FILL;
                if (desc_read && desc_len0 == '0) begin
                    d.ph1 = 1'b0;
                    d.c0  = desc_len1;
                end else begin
                    d.ph1 = 1'b1;
                    d.c0  = desc_len0;
                end
            end
        end else if (xfer_abort) begin
            d.st = S_IDLE; d.done = 1'b1; d.status = XS_ERROR;
        end else if (xfer_timeout) begin
            d.st = S_IDLE; d.done = 1'b1; d.status = XS_TIMEOUT;
        end else begin
            unique case (q.st)
                S_FILL: begin
                    if (q.c0 != '0) begin
                        if (!room) begin
                            d.st = S_WAIT_TX;
                        end else if (is_req || wr_valid) begin
                            push = 1'b1;
                            d.c0 = q.c0 - 1'b1;
                            d.bc = q.bc + 1'b1;
                        end
                    end else if (q.ph1 && q.c1 != '0) begin
                        d.c0  = q.c1;
                        d.ph1 = 1'b0;
                    end else begin
                        d.st = S_WAIT_END;
                    end
                end
                S_WAIT_TX: begin
                    if (tx_empty) d.st = q.rd ? S_DRAIN : S_FILL;
                end
                S_WAIT_END: begin
                    if (!q.rd) begin
                        if (tx_empty) begin
                            d.st = S_IDLE; d.done = 1'b1; d.status = XS_OK;
                        end
                    end else if (q.c1 == '0) begin
                        d.st = S_IDLE; d.done = 1'b1; d.status = XS_OK;
                    end else if (rx_full) begin
                        d.st = S_DRAIN;
                    end
                end
                S_DRAIN: begin
                    if (32'(rx_level) > 32'(q.c1)) begin
                        d.st = S_IDLE; d.done = 1'b1; d.status = XS_ERROR;
                    end else if (rx_level != '0) begin
                        rx_pop = 1'b1;
                        d.c1   = q.c1 - 1'b1;
                    end else if (q.c0 != '0 || (q.ph1 && q.c1 != '0)) begin
                        d.st = S_FILL;
                    end else if (q.c1 == '0) begin
                        d.st = S_IDLE; d.done = 1'b1; d.status = XS_OK;
                    end else begin
                        d.st = S_WAIT_END;
                    end
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= S_IDLE;
            q.status <= XS_OK;
        end else begin
            q <= d;
        end
    end

    assign desc_ready  = (q.st == S_IDLE);
    assign cmd_push    = push;
    assign cmd_word    = word;
    assign wr_ready    = push && !is_req;
    assign tx_wake_en  = (q.st == S_WAIT_TX) || (q.st == S_WAIT_END && !q.rd);
    assign rx_wake_en  = (q.st == S_WAIT_END) && q.rd;
    assign tx_thresh   = (q.st == S_WAIT_TX) ? LVL_W'(TX_WAKE_LVL) : '0;
    assign rx_thresh   = (q.c1 != '0) ? q.c1 - 1'b1 : '0;
    assign rd_valid    = rx_pop;
    assign rd_data     = rx_data;
    assign done_valid  = q.done;
    assign done_status = q.status;
endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker #(
    parameter int FIFO_DEPTH = 64,
    parameter int RX_SLACK   = 2,
    parameter int LVL_W      = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             desc_ready,
    input logic             cmd_push,
    input logic [10:0]      cmd_word,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic             rx_pop,
    input logic             tx_wake_en,
    input logic             rx_wake_en,
    input logic             done_valid,
    input logic [1:0]       done_status
);
    p_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_push |-> 32'(tx_level) < FIFO_DEPTH);

    p_slack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_push && cmd_word[8]) |-> 32'(tx_level) < FIFO_DEPTH - RX_SLACK);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> (!cmd_push && !rx_pop));

    p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> rx_level != '0);

    p_one_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_wake_en && rx_wake_en));

    p_done_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (!tx_wake_en && !rx_wake_en));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    p_done_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> done_status != 2'd3);
endmodule

bind i2c_cmd_sequencer i2cseq_checker #(
    .FIFO_DEPTH(FIFO_DEPTH), .RX_SLACK(RX_SLACK), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .desc_ready(desc_ready), .cmd_push(cmd_push),
    .cmd_word(cmd_word), .tx_level(tx_level), .rx_level(rx_level), .rx_pop(rx_pop),
    .tx_wake_en(tx_wake_en), .rx_wake_en(rx_wake_en), .done_valid(done_valid),
    .done_status(done_status)
);

// File: tb/i2c_cmd_sequencer_test.sv
module i2c_cmd_sequencer_test;
    localparam int DEPTH = 64;
    localparam int CNT_W = 8;
    localparam int LVL_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic desc_valid = 0, desc_ready, desc_read = 0, desc_restart = 0, desc_stop = 0;
    logic [CNT_W-1:0] desc_len0 = '0, desc_len1 = '0;
    logic wr_valid = 0, wr_ready;
    logic [7:0] wr_data = '0;
    logic cmd_push;
    logic [10:0] cmd_word;
    logic [LVL_W-1:0] tx_level = '0, tx_thresh, rx_level = '0;
    logic tx_wake_en, tx_empty = 0, rx_pop, rx_wake_en, rx_full = 0, rd_valid;
    logic [7:0] rx_data = '0, rd_data;
    logic [CNT_W-1:0] rx_thresh;
    logic xfer_abort = 0, xfer_timeout = 0, done_valid;
    logic [1:0] done_status;

    i2c_cmd_sequencer uut (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_read(desc_read), .desc_restart(desc_restart), .desc_stop(desc_stop),
        .desc_len0(desc_len0), .desc_len1(desc_len1), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_ready(wr_ready), .cmd_push(cmd_push), .cmd_word(cmd_word),
        .tx_level(tx_level), .tx_thresh(tx_thresh), .tx_wake_en(tx_wake_en),
        .tx_empty(tx_empty), .rx_level(rx_level), .rx_data(rx_data), .rx_pop(rx_pop),
        .rx_thresh(rx_thresh), .rx_wake_en(rx_wake_en), .rx_full(rx_full),
        .rd_valid(rd_valid), .rd_data(rd_data), .xfer_abort(xfer_abort),
        .xfer_timeout(xfer_timeout), .done_valid(done_valid), .done_status(done_status)
    );

    int checks = 0, fails = 0;
    logic [10:0] exp_cmd[$];
    logic [7:0]  exp_rd[$];
    logic [10:0] tx_q[$];
    logic [7:0]  rx_q[$];
    logic [7:0]  wr_q[$];
    bit loose = 0, got_done = 0, inject = 0;
    bit saw16 = 0, saw0 = 0, slack_bad = 0, full_bad = 0;
    logic [1:0] got_status = 2'd0;
    int cdiv = 1, rx_gen = 0, exp_ctr = 0, cyc = 0, seed_b = 64;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Controller and FIFO model plus scoreboard monitor
    initial begin
        logic [10:0] w;
        logic [7:0] e;
        forever begin
            @(negedge clk);
            cyc++;
            tx_level = LVL_W'(tx_q.size());
            rx_level = LVL_W'(rx_q.size());
            rx_data  = (rx_q.size() != 0) ? rx_q[0] : 8'h00;
            wr_valid = (wr_q.size() != 0);
            wr_data  = wr_valid ? wr_q[0] : 8'h00;
            tx_empty = tx_wake_en && (tx_q.size() <= int'(tx_thresh));
            rx_full  = rx_wake_en && (rx_q.size() > int'(rx_thresh));
            #1;
            if (rst_n) begin
                if (tx_wake_en && tx_thresh == LVL_W'(16)) saw16 = 1;
                if (tx_wake_en && tx_thresh == '0) saw0 = 1;
                if (rx_wake_en && !loose)
                    check(int'(rx_thresh) == exp_rd.size() - 1, "R8", "rx_thresh",
                          int'(rx_thresh), exp_rd.size() - 1);
                if (cmd_push) begin
                    if (cmd_word[8] && tx_q.size() >= DEPTH - 2) slack_bad = 1;
                    if (tx_q.size() >= DEPTH) full_bad = 1;
                    if (!loose) begin
                        if (exp_cmd.size() == 0)
                            check(0, "R5", "unexpected command", int'(cmd_word), 0);
                        else begin
                            w = exp_cmd.pop_front();
                            check(cmd_word == w, "R3", "command word", int'(cmd_word), int'(w));
                        end
                    end
                    tx_q.push_back(cmd_word);
                end
                if (wr_ready && wr_q.size() != 0) void'(wr_q.pop_front());
                if (rx_pop && rx_q.size() != 0) begin
                    if (!loose) begin
                        e = (exp_rd.size() != 0) ? exp_rd.pop_front() : 8'hxx;
                        check(rd_valid && rd_data == e, "R8", "read byte", int'(rd_data), int'(e));
                    end
                    void'(rx_q.pop_front());
                end
                if (cdiv > 0 && (cyc % cdiv) == 0 && tx_q.size() != 0) begin
                    w = tx_q.pop_front();
                    if (w[8]) begin
                        rx_q.push_back(8'(rx_gen));
                        rx_gen++;
                        if (inject) begin
                            rx_q.push_back(8'hEE);
                            inject = 0;
                        end
                    end
                end
                if (done_valid) begin
                    got_done   = 1;
                    got_status = done_status;
                end
            end
        end
    end

    task automatic start_xfer(input bit rd, input bit rs, input bit sp, input int c0, input int c1);
        int total;
        int idx;
        logic [7:0] b;
        total = c0 + c1;
        idx = 0;
        for (int i = 0; i < c0; i++) begin
            b = 8'(seed_b); seed_b++; idx++;
            wr_q.push_back(b);
            exp_cmd.push_back({rs && idx == 1, sp && idx == total, 1'b0, b});
        end
        for (int i = 0; i < c1; i++) begin
            idx++;
            if (rd) begin
                exp_cmd.push_back({rs && idx == 1, sp && idx == total, 1'b1, 8'h00});
                exp_rd.push_back(8'(exp_ctr)); exp_ctr++;
            end else begin
                b = 8'(seed_b); seed_b++;
                wr_q.push_back(b);
                exp_cmd.push_back({rs && idx == 1, sp && idx == total, 1'b0, b});
            end
        end
        check(desc_ready == 1'b1, "R11", "ready when idle", int'(desc_ready), 1);
        desc_read = rd; desc_restart = rs; desc_stop = sp;
        desc_len0 = CNT_W'(c0); desc_len1 = CNT_W'(c1); desc_valid = 1;
        @(negedge clk); #2;
        desc_valid = 0;
    endtask

    task automatic wait_done(input logic [1:0] st, input string req);
        while (!got_done) begin @(negedge clk); #2; end
        got_done = 0;
        check(got_status == st, req, "status", int'(got_status), int'(st));
        check(!tx_wake_en && !rx_wake_en, "R10", "wakes masked",
              int'({tx_wake_en, rx_wake_en}), 0);
        if (!loose)
            check(exp_cmd.size() == 0 && exp_rd.size() == 0, req, "all items seen",
                  exp_cmd.size() + exp_rd.size(), 0);
    endtask

    task automatic cleanup();
        @(negedge clk); #2;
        tx_q.delete(); rx_q.delete(); wr_q.delete(); exp_cmd.delete(); exp_rd.delete();
        inject = 0; loose = 0; exp_ctr = rx_gen;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check(desc_ready == 1'b1, "R11", "reset ready", int'(desc_ready), 1);
        check(!cmd_push && !rx_pop, "R1", "reset quiet", int'({cmd_push, rx_pop}), 0);
        check(!done_valid && !tx_wake_en && !rx_wake_en, "R10", "reset outputs",
              int'({done_valid, tx_wake_en, rx_wake_en}), 0);
        rst_n = 1;
        @(negedge clk); #2;

        // R5 write-then-write with both flags
        cdiv = 1;
        start_xfer(0, 1, 1, 3, 2);
        wait_done(2'd0, "R5");

        // R4 write-then-read, stop only: no restart at direction change
        start_xfer(1, 0, 1, 2, 4);
        wait_done(2'd0, "R4");

        // R6 read with empty first phase; R11 busy descriptor ignored
        cdiv = 2;
        start_xfer(1, 1, 1, 0, 5);
        check(desc_ready == 1'b0, "R11", "busy not ready", int'(desc_ready), 0);
        desc_read = 0; desc_len0 = 8'd7; desc_len1 = 8'd0; desc_valid = 1;
        @(negedge clk); #2;
        desc_valid = 0;
        wait_done(2'd0, "R6");

        // R2 and R7: long read under slow drain
        saw16 = 0; slack_bad = 0; cdiv = 4;
        start_xfer(1, 1, 1, 0, 100);
        wait_done(2'd0, "R8");
        check(!slack_bad, "R2", "read slack kept", int'(slack_bad), 0);
        check(saw16, "R7", "threshold 16 wait", int'(saw16), 1);

        // R1, R7, R8: long write fills the FIFO
        saw16 = 0; saw0 = 0; full_bad = 0;
        start_xfer(0, 0, 1, 60, 60);
        wait_done(2'd0, "R1");
        check(!full_bad, "R1", "no push when full", int'(full_bad), 0);
        check(saw16, "R7", "threshold 16 wait", int'(saw16), 1);
        check(saw0, "R8", "drain wait threshold 0", int'(saw0), 1);

        // R10 abort on a stalled controller
        loose = 1; cdiv = 0;
        start_xfer(0, 1, 1, 10, 0);
        repeat (15) @(negedge clk);
        #2; xfer_abort = 1;
        @(negedge clk); #2; xfer_abort = 0;
        wait_done(2'd1, "R10");
        cleanup();

        // R10 timeout
        loose = 1; cdiv = 0;
        start_xfer(1, 0, 1, 0, 3);
        repeat (8) @(negedge clk);
        #2; xfer_timeout = 1;
        @(negedge clk); #2; xfer_timeout = 0;
        wait_done(2'd2, "R10");
        cleanup();

        // R9 surplus receive byte
        loose = 1; cdiv = 1; inject = 1;
        start_xfer(1, 0, 1, 0, 3);
        wait_done(2'd1, "R9");
        cleanup();

        // R4 single byte with no flags after error recovery
        cdiv = 1;
        start_xfer(0, 0, 0, 1, 0);
        wait_done(2'd0, "R4");

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule